// File: doc/BRIEF.md
# Transmit Burst Request Generator

This block drives the single DMA request line that refills a serial transmitter's data buffer. It compares the buffer's count of free locations with a programmed threshold. When the buffer has room for a full burst of threshold plus one words, it raises the request. It then counts the words the DMA engine writes into the buffer and drops the request once the burst is complete. When there is again enough room, it raises the request for the next burst.

Two inputs gate the request. The transmitter enable holds the whole block idle while it is low. The DMA enable only masks the output line, so a burst that is under way keeps its word count while the request is masked. When the enable returns, the burst carries on from where it stopped. The threshold is sampled when a burst starts, so a threshold written during a burst applies from the next burst on. The register that holds the threshold lives outside this block; its customary reset setting is 1, which gives two-word bursts.

Top module: `dmareq_tx`

## Requirements
- R1: While `tx_en` is low, `dma_req` is low and the word count is cleared, so a burst started after `tx_en` returns high is a full one.
- R2: A burst is `thresh`+1 buffer writes long; thresholds 0, 1 and 3 give bursts of 1, 2 and 4 words.
- R3: While `rst_n` is low, `dma_req` is low and the block is idle.
- R4: An idle block that sees `free_lvl` >= `thresh`+1 at a clock edge has `dma_req` high after that edge (with `tx_en` and `dma_en` high); with `free_lvl` <= `thresh` it stays idle.
- R5: `dma_req` falls after the edge that samples the last write of a burst. It can rise again at the earliest one edge later, once the room condition holds.
- R6: When `dma_en` is low, `dma_req` is low in the same cycle, with no clock edge needed. Writes made during a burst are still counted.
- R7: Setting `dma_en` high again during a burst brings `dma_req` back. The burst then ends after the words still missing from the held count.
- R8: `wr_stb` pulses while idle do not change the count of the next burst.
- R9: The compare is done one bit wider than the inputs, so `thresh` at all ones never wraps to zero and never gives a request.
- R10: `thresh` is captured when a burst starts; changing it during the burst does not change that burst's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmitter out of reset; low holds the block idle |
| dma_en | input | 1 | DMA request enable; masks the output only |
| thresh | input | LVL_W | Burst threshold; burst length is this value plus one |
| free_lvl | input | LVL_W | Number of free locations in the transmit buffer |
| wr_stb | input | 1 | One pulse per word written into the buffer |
| dma_req | output | 1 | DMA request to the transmit channel |

## Verification
A start or end of burst appears on `dma_req` after the single clock edge that samples the room condition or the last write. The two enables act on `dma_req` with no added cycle. Inputs are driven on the falling edge, and each driven cycle pushes the value expected after the next rising edge. The monitor pops that value one time step after the rising edge, so the register update and any same-cycle masking have both settled. Most checks run with threshold values where a wrapped compare or a miscounted or reset count would end a burst on a different cycle. This makes such defects show up as a wrong value at a single sampled point.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } burst_st_t;
endpackage

// File: rtl/dmareq_room_cmp.sv
// Decides whether the buffer has room for a full burst.
// The compare is one bit wider than the inputs so threshold+1 cannot wrap.
module dmareq_room_cmp #(
  parameter int LVL_W = 4
) (
  input  logic [LVL_W-1:0] thresh,
  input  logic [LVL_W-1:0] free_lvl,
  output logic             room_ok
);
  localparam int CMP_W = LVL_W + 1;

  logic [CMP_W-1:0] need_w;
  logic [CMP_W-1:0] have_w;

  always_comb begin
    need_w  = {1'b0, thresh} + CMP_W'(1);
    have_w  = {1'b0, free_lvl};
    room_ok = (have_w >= need_w);
  end
endmodule

// File: rtl/dmareq_word_ctr.sv
// Holds the length captured at burst start and counts the words written.
module dmareq_word_ctr #(
  parameter int LVL_W      = 4,
  parameter int RST_THRESH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic             inc,
  input  logic [LVL_W-1:0] thresh,
  output logic             last
);
  logic [LVL_W-1:0] len_m1_q;
  logic [LVL_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_m1_q <= LVL_W'(RST_THRESH);
      cnt_q    <= '0;
    end else if (clr) begin
      cnt_q    <= '0;
    end else if (start) begin
      len_m1_q <= thresh;
      cnt_q    <= '0;
    end else if (inc) begin
      cnt_q    <= (cnt_q == len_m1_q) ? '0 : cnt_q + LVL_W'(1);
    end
  end

  assign last = (cnt_q == len_m1_q);
endmodule

// File: rtl/dmareq_tx.sv
module dmareq_tx #(
  parameter int LVL_W      = 4,
  parameter int RST_THRESH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             dma_en,
  input  logic [LVL_W-1:0] thresh,
  input  logic [LVL_W-1:0] free_lvl,
  input  logic             wr_stb,
  output logic             dma_req
);
  import dmareq_pkg::*;

  burst_st_t st_q, st_d;
  logic      room_ok;
  logic      start;
  logic      burst_wr;
  logic      last_word;

  dmareq_room_cmp #(.LVL_W(LVL_W)) u_cmp (
    .thresh   (thresh),
    .free_lvl (free_lvl),
    .room_ok  (room_ok)
  );

  // The count advances on writes inside a burst, whatever dma_en is.
  assign start    = tx_en && (st_q == ST_IDLE) && room_ok;
  assign burst_wr = tx_en && (st_q == ST_BURST) && wr_stb;

  dmareq_word_ctr #(.LVL_W(LVL_W), .RST_THRESH(RST_THRESH)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!tx_en),
    .start  (start),
    .inc    (burst_wr),
    .thresh (thresh),
    .last   (last_word)
  );

  always_comb begin
    st_d = st_q;
    if (!tx_en)                  st_d = ST_IDLE;
    else if (start)              st_d = ST_BURST;
    else if (burst_wr && last_word) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // The DMA enable only masks the line; burst state is kept.
  assign dma_req = tx_en && dma_en && (st_q == ST_BURST);
endmodule

// File: rtl/dmareq_tx_chk.sv
module dmareq_tx_chk #(
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             dma_en,
  input logic [LVL_W-1:0] thresh,
  input logic [LVL_W-1:0] free_lvl,
  input logic             dma_req
);
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !dma_req); // R1

  AST_DMA_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !dma_req); // R6

  AST_ROOM_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dma_req) && $stable(dma_en) && $stable(tx_en)) |->
      ({1'b0, $past(free_lvl)} >= ({1'b0, $past(thresh)} + (LVL_W+1)'(1)))); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_req && dma_en && tx_en && (&thresh)) |=> !dma_req); // R9
endmodule

bind dmareq_tx dmareq_tx_chk #(.LVL_W(LVL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_en    (tx_en),
  .dma_en   (dma_en),
  .thresh   (thresh),
  .free_lvl (free_lvl),
  .dma_req  (dma_req)
);

// File: tb/dmareq_tx_tb.sv
module dmareq_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W      = 4;

  typedef struct {
    bit    exp;
    string tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tx_en = 1'b0;
  logic             dma_en = 1'b0;
  logic [LVL_W-1:0] thresh = '0;
  logic [LVL_W-1:0] free_lvl = '0;
  logic             wr_stb = 1'b0;
  logic             dma_req;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dmareq_tx #(.LVL_W(LVL_W), .RST_THRESH(1)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .dma_en   (dma_en),
    .thresh   (thresh),
    .free_lvl (free_lvl),
    .wr_stb   (wr_stb),
    .dma_req  (dma_req)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: dma_req=%0b expected %0b", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of inputs and queue the value due after the next edge.
  task automatic step(input bit tx, input bit dma, input int th, input int fl,
                      input bit wr, input bit exp, input string tag);
    exp_t e;
    @(negedge clk);
    tx_en    = tx;
    dma_en   = dma;
    thresh   = LVL_W'(th);
    free_lvl = LVL_W'(fl);
    wr_stb   = wr;
    e.exp = exp;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: sample just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(dma_req, e.exp, e.tag);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    end
  end

  initial begin
    tx_en = 1'b1; dma_en = 1'b1; thresh = 4'd1; free_lvl = 4'd15;
    repeat (3) @(negedge clk);
    check(dma_req, 1'b0, "R3 reset holds request low");
    rst_n = 1'b1;
    tx_en = 1'b0;
    // R1: transmitter held in reset
    step(0, 1, 1, 15, 0, 0, "R1 request low with tx_en low");
    // R4 / R2 (threshold 1 -> 2 words) / R5
    step(1, 1, 1, 15, 0, 1, "R4 request after room seen");
    step(1, 1, 1, 15, 1, 1, "R2 first of two words");
    step(1, 1, 1, 15, 1, 0, "R5 drop after last word");
    step(1, 1, 1, 15, 0, 1, "R5 reassert when room again");
    step(1, 1, 1, 15, 1, 1, "R2 burst continues");
    step(1, 1, 1, 1,  1, 0, "R5 drop at burst end");
    step(1, 1, 1, 1,  0, 0, "R4 no request when free below thresh+1");
    step(1, 1, 1, 2,  0, 1, "R4 request when free equals thresh+1");
    // R6 / R7: mask and resume
    step(1, 0, 1, 2,  0, 0, "R6 mask drops request at once");
    step(1, 0, 1, 2,  1, 0, "R6 masked write");
    step(1, 1, 1, 2,  0, 1, "R7 request back on re-enable");
    step(1, 1, 1, 0,  1, 0, "R7 burst ends on held count");
    // R8: idle writes ignored
    step(1, 1, 1, 0,  1, 0, "R8 idle write");
    step(1, 1, 1, 0,  1, 0, "R8 idle write");
    step(1, 1, 1, 15, 0, 1, "R8 new burst starts");
    step(1, 1, 1, 15, 1, 1, "R8 count starts from zero");
    step(1, 1, 1, 15, 1, 0, "R8 burst ends after two words");
    // R9: maximum threshold never requests
    step(1, 1, 15, 15, 0, 0, "R9 max threshold no request");
    step(1, 1, 15, 15, 0, 0, "R9 max threshold no request");
    // R2: threshold 0 -> 1 word
    step(1, 1, 0, 1,  0, 1, "R2 threshold 0 request");
    step(1, 1, 0, 0,  1, 0, "R2 one-word burst");
    // R2: threshold 3 -> 4 words
    step(1, 1, 3, 4,  0, 1, "R2 threshold 3 request");
    step(1, 1, 3, 0,  1, 1, "R2 word 1 of 4");
    step(1, 1, 3, 0,  1, 1, "R2 word 2 of 4");
    step(1, 1, 3, 0,  1, 1, "R2 word 3 of 4");
    step(1, 1, 3, 0,  1, 0, "R2 word 4 of 4 ends burst");
    // R1: tx reset mid-burst clears count
    step(1, 1, 1, 15, 0, 1, "R1 burst start");
    step(1, 1, 1, 15, 1, 1, "R1 one word written");
    step(0, 1, 1, 15, 0, 0, "R1 tx reset drops request");
    step(1, 1, 1, 15, 0, 1, "R1 fresh burst");
    step(1, 1, 1, 15, 1, 1, "R1 count was cleared");
    step(1, 1, 1, 0,  1, 0, "R1 full two-word burst");
    // R10: threshold captured at burst start
    step(1, 1, 1, 15, 0, 1, "R10 burst start with threshold 1");
    step(1, 1, 3, 15, 1, 1, "R10 threshold change mid-burst");
    step(1, 1, 3, 0,  1, 0, "R10 captured length used");
    step(0, 0, 1, 0,  0, 0, "R1 final idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule